// File: doc/BRIEF.md
# Byte-Serial Instruction Length Decoder

This block sits at the front of a 16-bit instruction pipeline. Instruction bytes arrive one per cycle on a valid/ready input. The decoder walks each variable-length instruction, which is 1 to 6 bytes long, and works out where it ends. When the final byte is accepted, it hands out one record with the instruction's decoded fields and its total length.

From the opcode byte the block takes the direction bit and the width bit. From the operand byte it takes the mode, register and register/memory fields. Next it decides how many displacement bytes follow, using the mode and the register/memory field. Then it decides how many immediate bytes follow, using the sign-extend and width bits. Multi-byte values arrive low byte first.

Only a few instruction families are recognised:
- register/memory add,
- the immediate group, where the register field extends the opcode,
- the two increment forms.

Any other opcode byte produces a one-byte record marked illegal.

Top module: `instr_len_decoder`

## Requirements
- R1: Opcode bit 1 is reported as `rec_dbit` and bit 0 as `rec_wide`, for the add, immediate and increment-group opcodes. The operand byte is split into `rec_mode` = bits 7:6, `rec_reg` = bits 5:3 and `rec_rm` = bits 2:0.
- R2: The number of displacement bytes depends on the mode field. Mode 01 takes one byte. Mode 10 takes two. Mode 11 takes none. Mode 00 takes none, except when r/m is 110, where a two-byte direct address follows.
- R3: A one-byte displacement is sign-extended into `rec_disp`. A two-byte displacement is assembled little-endian.
- R4: Only the immediate group (opcodes 0x80 to 0x83, with S = bit 1 and W = bit 0) takes an immediate, and it follows any displacement. S=0,W=0 takes one byte, zero-extended. S=0,W=1 takes two bytes, little-endian. S=1,W=1 takes one byte, sign-extended to 16 bits, and raises `rec_sext`.
- R5: S=1,W=0 raises `rec_bad_sw`. That form consumes one immediate byte, zero-extended.
- R6: In the immediate group the register field is treated as an opcode extension. It is reported unchanged in `rec_reg`.
- R7: `rec_kind` encodes the instruction family: 0 = add (opcodes 0x00 to 0x03), 1 = immediate group, 2 = increment group (0xFE/0xFF), 3 = short increment (0x40 to 0x47). A short increment is a 1-byte word record with `rec_reg` and `rec_rm` equal to opcode bits 2:0 and `rec_mode` = 11.
- R8: Any other opcode byte gives a 1-byte record with `rec_illegal` = 1 and `rec_kind` = 0. The next byte is decoded as a new opcode.
- R9: `rec_valid` pulses for exactly one cycle, in the cycle after the final byte is accepted. `rec_len` equals the number of bytes consumed (1 to 6). Back-to-back instructions need no idle cycles.
- R10: A synchronous reset returns the decoder to opcode fetch and discards a partially collected instruction.
- R11: Cycles with `in_valid` low do not advance decoding.
- R12: `in_ready` is high whenever reset is not asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder accepts a byte |
| rec_valid | output | 1 | Decoded record present (one cycle) |
| rec_len | output | 3 | Instruction length in bytes |
| rec_kind | output | 2 | Instruction family |
| rec_dbit | output | 1 | Opcode bit 1 (direction, or sign-extend in the immediate group) |
| rec_wide | output | 1 | Word operation |
| rec_sext | output | 1 | Immediate was sign-extended |
| rec_mode | output | 2 | Mode field |
| rec_reg | output | 3 | Register field or opcode extension |
| rec_rm | output | 3 | Register/memory field |
| rec_disp | output | 16 | Displacement |
| rec_imm | output | 16 | Immediate |
| rec_illegal | output | 1 | Opcode not supported |
| rec_bad_sw | output | 1 | Invalid S/W combination |

## Verification
The hardest situation to reach from the ports is a reset that arrives while an instruction is only partly collected. This matters most when the displacement bytes are already in and the immediate bytes are still due, because stale state could corrupt the next record. The bench feeds the first bytes of a six-byte immediate form, asserts reset, and then sends a short increment. That record must come out with length 1 and no leftover fields. A separate test puts idle cycles between the bytes of a single instruction, to show that bubbles do not shift the byte count.

// File: rtl/instr_len_decoder.sv
module instr_len_decoder (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        rec_valid,
  output logic [2:0]  rec_len,
  output logic [1:0]  rec_kind,
  output logic        rec_dbit,
  output logic        rec_wide,
  output logic        rec_sext,
  output logic [1:0]  rec_mode,
  output logic [2:0]  rec_reg,
  output logic [2:0]  rec_rm,
  output logic [15:0] rec_disp,
  output logic [15:0] rec_imm,
  output logic        rec_illegal,
  output logic        rec_bad_sw
);

  localparam logic [1:0] K_ADD = 2'd0, K_IMM = 2'd1, K_INC = 2'd2, K_INCS = 2'd3;

  typedef enum logic [2:0] {ST_OP, ST_MODRM, ST_DLO, ST_DHI, ST_ILO, ST_IHI} st_t;

  typedef struct packed {
    logic [2:0]  len;
    logic [1:0]  kind;
    logic        dbit;
    logic        wide;
    logic [1:0]  mode;
    logic [2:0]  rg;
    logic [2:0]  rm;
    logic [15:0] disp;
    logic [15:0] imm;
    logic        ill;
  } rec_t;

  st_t  state, state_n;
  rec_t cur, nxt, out;
  logic done;

  wire take     = in_valid && in_ready;
  wire cur_two  = (cur.mode == 2'b10) || (cur.mode == 2'b00 && cur.rm == 3'b110);
  wire in_two   = (in_byte[7:6] == 2'b10) || (in_byte[7:6] == 2'b00 && in_byte[2:0] == 3'b110);
  wire in_one   = (in_byte[7:6] == 2'b01);
  wire has_imm  = (cur.kind == K_IMM);
  wire imm_two  = has_imm && !cur.dbit && cur.wide;

  assign in_ready = !rst;

  always_comb begin
    nxt     = cur;
    state_n = state;
    done    = 1'b0;
    if (take) begin
      nxt.len = cur.len + 3'd1;
      unique case (state)
        ST_OP: begin
          nxt      = '0;
          nxt.len  = 3'd1;
          nxt.dbit = in_byte[1];
          nxt.wide = in_byte[0];
          if (in_byte[7:2] == 6'b000000) begin
            nxt.kind = K_ADD;
            state_n  = ST_MODRM;
          end else if (in_byte[7:2] == 6'b100000) begin
            nxt.kind = K_IMM;
            state_n  = ST_MODRM;
          end else if (in_byte[7:1] == 7'b1111111) begin
            nxt.kind = K_INC;
            state_n  = ST_MODRM;
          end else if (in_byte[7:3] == 5'b01000) begin
            nxt.kind = K_INCS;
            nxt.dbit = 1'b0;
            nxt.wide = 1'b1;
            nxt.mode = 2'b11;
            nxt.rg   = in_byte[2:0];
            nxt.rm   = in_byte[2:0];
            done     = 1'b1;
          end else begin
            nxt.ill  = 1'b1;
            done     = 1'b1;
          end
        end
        ST_MODRM: begin
          nxt.mode = in_byte[7:6];
          nxt.rg   = in_byte[5:3];
          nxt.rm   = in_byte[2:0];
          if (in_one || in_two) state_n = ST_DLO;
          else if (has_imm)     state_n = ST_ILO;
          else                  done    = 1'b1;
        end
        ST_DLO: begin
          nxt.disp = {{8{in_byte[7]}}, in_byte};
          if (cur_two)      state_n = ST_DHI;
          else if (has_imm) state_n = ST_ILO;
          else              done    = 1'b1;
        end
        ST_DHI: begin
          nxt.disp[15:8] = in_byte;
          if (has_imm) state_n = ST_ILO;
          else         done    = 1'b1;
        end
        ST_ILO: begin
          nxt.imm = (cur.dbit && cur.wide) ? {{8{in_byte[7]}}, in_byte} : {8'h00, in_byte};
          if (imm_two) state_n = ST_IHI;
          else         done    = 1'b1;
        end
        ST_IHI: begin
          nxt.imm[15:8] = in_byte;
          done          = 1'b1;
        end
        default: state_n = ST_OP;
      endcase
      if (done) state_n = ST_OP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OP;
      cur       <= '0;
      out       <= '0;
      rec_valid <= 1'b0;
    end else begin
      state     <= state_n;
      cur       <= nxt;
      rec_valid <= done;
      if (done) out <= nxt;
    end
  end

  assign rec_len     = out.len;
  assign rec_kind    = out.kind;
  assign rec_dbit    = out.dbit;
  assign rec_wide    = out.wide;
  assign rec_mode    = out.mode;
  assign rec_reg     = out.rg;
  assign rec_rm      = out.rm;
  assign rec_disp    = out.disp;
  assign rec_imm     = out.imm;
  assign rec_illegal = out.ill;
  assign rec_sext    = (out.kind == K_IMM) && out.dbit && out.wide;
  assign rec_bad_sw  = (out.kind == K_IMM) && out.dbit && !out.wide;

endmodule

module instr_len_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        rec_valid,
  input logic [2:0]  rec_len,
  input logic [1:0]  rec_kind,
  input logic        rec_wide,
  input logic [1:0]  rec_mode,
  input logic [15:0] rec_imm,
  input logic        rec_illegal,
  input logic        rec_bad_sw
);
  assert_len_range_R9: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_len >= 3'd1 && rec_len <= 3'd6));
  assert_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> $past(in_valid && in_ready));
  assert_illegal_short_R8: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_illegal) |-> (rec_len == 3'd1 && rec_kind == 2'd0));
  assert_short_inc_R7: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_kind == 2'd3) |-> (rec_len == 3'd1 && rec_wide));
  assert_bad_sw_R5: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_bad_sw) |-> (rec_kind == 2'd1 && rec_imm[15:8] == 8'h00));
  assert_regmode_R2: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_mode == 2'b11 && rec_kind != 2'd1) |-> (rec_len <= 3'd2));
  assert_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rec_valid);
  assert_ready_R12: assert property (@(posedge clk) !rst |-> in_ready);
endmodule

bind instr_len_decoder instr_len_decoder_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .rec_valid(rec_valid), .rec_len(rec_len), .rec_kind(rec_kind),
  .rec_wide(rec_wide), .rec_mode(rec_mode), .rec_imm(rec_imm),
  .rec_illegal(rec_illegal), .rec_bad_sw(rec_bad_sw)
);

// File: tb/tb_instr_len_decoder.sv
module tb_instr_len_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, rec_valid, rec_dbit, rec_wide, rec_sext, rec_illegal, rec_bad_sw;
  logic [2:0] rec_len, rec_reg, rec_rm;
  logic [1:0] rec_kind, rec_mode;
  logic [15:0] rec_disp, rec_imm;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_len_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .rec_valid(rec_valid), .rec_len(rec_len), .rec_kind(rec_kind), .rec_dbit(rec_dbit),
    .rec_wide(rec_wide), .rec_sext(rec_sext), .rec_mode(rec_mode), .rec_reg(rec_reg),
    .rec_rm(rec_rm), .rec_disp(rec_disp), .rec_imm(rec_imm), .rec_illegal(rec_illegal),
    .rec_bad_sw(rec_bad_sw)
  );

  typedef struct packed {
    logic [47:0] b;
    logic [2:0]  n;
    logic [1:0]  kind;
    logic        d;
    logic        w;
    logic [2:0]  rg;
    logic [2:0]  rm;
    logic [15:0] disp;
    logic [15:0] imm;
    logic        ill;
    logic        bad;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{48'h81C0AA550000, 3'd4, 2'd1, 1'b0, 1'b1, 3'd0, 3'd0, 16'h0000, 16'h55AA, 1'b0, 1'b0},
    '{48'h0306AA550000, 3'd4, 2'd0, 1'b1, 1'b1, 3'd0, 3'd6, 16'h55AA, 16'h0000, 1'b0, 1'b0},
    '{48'hFEC000000000, 3'd2, 2'd2, 1'b1, 1'b0, 3'd0, 3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0},
    '{48'hFFC000000000, 3'd2, 2'd2, 1'b1, 1'b1, 3'd0, 3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0},
    '{48'h400000000000, 3'd1, 2'd3, 1'b0, 1'b1, 3'd0, 3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0},
    '{48'h8346F0800000, 3'd4, 2'd1, 1'b1, 1'b1, 3'd0, 3'd6, 16'hFFF0, 16'hFF80, 1'b0, 1'b0},
    '{48'h80873412_7F00, 3'd5, 2'd1, 1'b0, 1'b0, 3'd0, 3'd7, 16'h1234, 16'h007F, 1'b0, 1'b0},
    '{48'h81B80001CDAB, 3'd6, 2'd1, 1'b0, 1'b1, 3'd7, 3'd0, 16'h0100, 16'hABCD, 1'b0, 1'b0},
    '{48'h82C190000000, 3'd3, 2'd1, 1'b1, 1'b0, 3'd0, 3'd1, 16'h0000, 16'h0090, 1'b0, 1'b1},
    '{48'h0F0000000000, 3'd1, 2'd0, 1'b1, 1'b1, 3'd0, 3'd0, 16'h0000, 16'h0000, 1'b1, 1'b0},
    '{48'h024580000000, 3'd3, 2'd0, 1'b1, 1'b0, 3'd0, 3'd5, 16'hFF80, 16'h0000, 1'b0, 1'b0},
    '{48'h470000000000, 3'd1, 2'd3, 1'b0, 1'b1, 3'd7, 3'd7, 16'h0000, 16'h0000, 1'b0, 1'b0},
    '{48'h00D800000000, 3'd2, 2'd0, 1'b0, 1'b0, 3'd3, 3'd0, 16'h0000, 16'h0000, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic check_rec(input vec_t v, input int i);
    string s;
    s = $sformatf("vec%0d", i);
    check(rec_valid === 1'b1, {s, " R9 valid"}, 16'(rec_valid), 16'd1);
    check(rec_len == v.n, {s, " R9 len"}, 16'(rec_len), 16'(v.n));
    check(rec_kind == v.kind, {s, " R7 kind"}, 16'(rec_kind), 16'(v.kind));
    check(rec_illegal == v.ill, {s, " R8 illegal"}, 16'(rec_illegal), 16'(v.ill));
    if (!v.ill) begin
      check({rec_dbit, rec_wide} == {v.d, v.w}, {s, " R1 d/w"}, 16'({rec_dbit, rec_wide}), 16'({v.d, v.w}));
      check(rec_reg == v.rg && rec_rm == v.rm, {s, " R1 R6 reg/rm"}, 16'({rec_reg, rec_rm}), 16'({v.rg, v.rm}));
      check(rec_disp == v.disp, {s, " R2 R3 disp"}, rec_disp, v.disp);
      check(rec_imm == v.imm, {s, " R4 imm"}, rec_imm, v.imm);
      check(rec_bad_sw == v.bad, {s, " R5 bad_sw"}, 16'(rec_bad_sw), 16'(v.bad));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rec_valid === 1'b0, "R10 no record in reset", 16'(rec_valid), 16'd0);
    check(in_ready === 1'b0, "R12 ready low in reset", 16'(in_ready), 16'd0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready === 1'b1, "R12 ready after reset", 16'(in_ready), 16'd1);
    check(rec_valid === 1'b0, "R10 idle after reset", 16'(rec_valid), 16'd0);

    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VEC[i].n); k++) begin
        in_valid = 1'b1;
        in_byte  = VEC[i].b[47 - 8*k -: 8];
        @(posedge clk);
        @(negedge clk);
        if (k == int'(VEC[i].n) - 1) check_rec(VEC[i], i);
        else check(rec_valid === 1'b0, "R9 no early record", 16'(rec_valid), 16'd0);
      end
    end
    in_valid = 1'b0;
    @(negedge clk);
    check(rec_valid === 1'b0, "R9 single-cycle pulse", 16'(rec_valid), 16'd0);

    // R11: idle gaps inside FF C0
    push(8'hFF);
    repeat (3) begin
      @(negedge clk);
      check(rec_valid === 1'b0, "R11 gap no record", 16'(rec_valid), 16'd0);
    end
    push(8'hC0);
    check(rec_valid === 1'b1 && rec_len == 3'd2, "R11 len after gaps", 16'(rec_len), 16'd2);

    // R10: reset mid-instruction after displacement, immediate still due
    push(8'h81); push(8'hB8); push(8'h00); push(8'h01); push(8'hCD);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    push(8'h40);
    check(rec_valid === 1'b1 && rec_len == 3'd1, "R10 fresh after reset len", 16'(rec_len), 16'd1);
    check(rec_kind == 2'd3 && rec_imm == 16'h0 && rec_disp == 16'h0, "R10 no stale fields",
          rec_imm | rec_disp, 16'h0);

    // R8: illegal byte followed directly by a new opcode
    push(8'hC3);
    check(rec_illegal === 1'b1 && rec_len == 3'd1, "R8 illegal record", 16'(rec_illegal), 16'd1);
    push(8'h45);
    check(rec_kind == 2'd3 && rec_reg == 3'd5, "R8 next byte is opcode", 16'(rec_reg), 16'd5);

    // R4: sign-extended positive immediate stays positive, rec_sext set
    push(8'h83); push(8'hC0); push(8'h7F);
    check(rec_imm == 16'h007F && rec_sext, "R4 sext positive", rec_imm, 16'h007F);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule